// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Waveform Generator

A 16-bit timer/counter that runs either as a plain up counter, as a clear-on-compare counter, as a single-slope PWM generator or as a dual-slope PWM generator. A 4-bit mode field picks one of sixteen configurations. Each configuration fixes four things: the counting style, where the TOP value comes from, when a write to a compare register reaches the comparator, and which counter event sets the overflow flag. Two compare channels, A and B, each drive one PWM output.

The count enable input stands in for a prescaled tick, so the counter moves one step only on enabled cycles. Compare register A, compare register B and the capture/TOP register are written over a shared data bus, with one write strobe per register. The overflow flag stays set until it is cleared by a strobe.

Top module: `wavegen_timer`

## Requirements
- R1: Asynchronous active-low reset sets the count to 0, clears the overflow flag, both PWM outputs, both compare registers (buffered and active copies) and the capture register, and sets the count direction to up.
- R2: The count and all counter events change only on clock edges where `cnt_en_i` is high. With the enable low the count holds.
- R3: Mode 0 and the reserved mode 13 count up from 0 to 0xFFFF and wrap to 0. The overflow flag sets on the edge that leaves 0xFFFF.
- R4: Modes 4 and 12 are clear-on-compare. TOP is the active compare A (mode 4) or the capture register (mode 12). The count goes to 0 on the edge that leaves TOP. The overflow flag sets only when leaving 0xFFFF, never at TOP.
- R5: Fast PWM modes 5, 6, 7, 14 and 15 count up and wrap to 0 after TOP. TOP is 0x00FF, 0x01FF, 0x03FF, the capture register, or the active compare A. The overflow flag sets on the edge that leaves TOP.
- R6: Dual-slope modes 1, 2, 3 (TOP 0x00FF/0x01FF/0x03FF), 8 and 10 (TOP = capture), and 9 and 11 (TOP = active compare A) count up to TOP, then down to 0, then up again. Each extreme value is held for exactly one count. The overflow flag sets on the edge that leaves 0 while counting down.
- R7: A compare write always updates the buffer. The active compare value takes the written value in the same edge in modes 0, 4, 12 and 13. It takes the buffer on the edge that leaves TOP in modes 1–3, 5–7, 10, 11, 14 and 15. It takes the buffer on the edge that leaves 0 while counting down in modes 8 and 9.
- R8: In fast PWM a channel output sets on the edge that wraps the count to 0 and clears on the edge that leaves a count equal to its active compare value. If both happen in the same count, the output sets. The output is therefore high exactly while count ≤ compare.
- R9: In dual-slope PWM a channel output clears when a count equal to its active compare value is left while counting up, and sets when such a count is left while counting down.
- R10: In modes 0, 4, 12 and 13 both PWM outputs are held low.
- R11: The overflow flag is sticky. A high on `ovf_clr_i` clears it on the next edge. When a set event and a clear fall on the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable (one tick per high cycle) |
| mode_i | input | 4 | Waveform mode, 0 to 15 |
| ocra_we_i | input | 1 | Write strobe for compare register A |
| ocrb_we_i | input | 1 | Write strobe for compare register B |
| cap_we_i | input | 1 | Write strobe for capture/TOP register |
| wdata_i | input | 16 | Write data shared by the three registers |
| ovf_clr_i | input | 1 | Clear strobe for the overflow flag |
| cnt_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| pwm_a_o | output | 1 | Waveform output of channel A |
| pwm_b_o | output | 1 | Waveform output of channel B |

## Verification
Clearing the overflow flag and setting it from a counter event can land on the same edge. In fast PWM mode 14 with a capture TOP of 3, the bench first sets the flag by running past TOP and clears it with an idle strobe. It then steps the count back to TOP and raises the enable and the clear strobe together, so the set event and the clear share one edge. The flag must read set afterwards, while the idle clear alone must read it clear. In the same way, a compare equal to TOP in fast PWM puts the wrap set and the match clear on one edge, and the output must stay high.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

  typedef enum logic [1:0] {K_NORM, K_CTC, K_FAST, K_DUAL} kind_e;
  typedef enum logic [2:0] {T_MAX, T_8B, T_9B, T_10B, T_CMPA, T_CAP} top_e;
  typedef enum logic [1:0] {U_IMM, U_TOP, U_BOT} upd_e;
  typedef enum logic [1:0] {F_MAX, F_TOP, F_BOT} flg_e;

  typedef struct packed {
    kind_e kind;
    top_e  top;
    upd_e  upd;
    flg_e  flg;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    unique case (m)
      4'd1:    c = '{K_DUAL, T_8B,  U_TOP, F_BOT};
      4'd2:    c = '{K_DUAL, T_9B,  U_TOP, F_BOT};
      4'd3:    c = '{K_DUAL, T_10B, U_TOP, F_BOT};
      4'd4:    c = '{K_CTC,  T_CMPA, U_IMM, F_MAX};
      4'd5:    c = '{K_FAST, T_8B,  U_TOP, F_TOP};
      4'd6:    c = '{K_FAST, T_9B,  U_TOP, F_TOP};
      4'd7:    c = '{K_FAST, T_10B, U_TOP, F_TOP};
      4'd8:    c = '{K_DUAL, T_CAP, U_BOT, F_BOT};
      4'd9:    c = '{K_DUAL, T_CMPA, U_BOT, F_BOT};
      4'd10:   c = '{K_DUAL, T_CAP, U_TOP, F_BOT};
      4'd11:   c = '{K_DUAL, T_CMPA, U_TOP, F_BOT};
      4'd12:   c = '{K_CTC,  T_CAP, U_IMM, F_MAX};
      4'd14:   c = '{K_FAST, T_CAP, U_TOP, F_TOP};
      4'd15:   c = '{K_FAST, T_CMPA, U_TOP, F_TOP};
      default: c = '{K_NORM, T_MAX, U_IMM, F_MAX}; // 0 and reserved 13
    endcase
    return c;
  endfunction

endpackage

// File: rtl/wavegen_mode_dec.sv
module wavegen_mode_dec
  import wavegen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] cmpa_act_i,
  input  logic [CNT_W-1:0] cap_i,
  output mode_cfg_t        cfg_o,
  output logic [CNT_W-1:0] top_o
);
  localparam logic [CNT_W-1:0] TOP_8B  = CNT_W'(32'h00FF);
  localparam logic [CNT_W-1:0] TOP_9B  = CNT_W'(32'h01FF);
  localparam logic [CNT_W-1:0] TOP_10B = CNT_W'(32'h03FF);

  always_comb begin
    cfg_o = decode_mode(mode_i);
    unique case (cfg_o.top)
      T_8B:    top_o = TOP_8B;
      T_9B:    top_o = TOP_9B;
      T_10B:   top_o = TOP_10B;
      T_CMPA:  top_o = cmpa_act_i;
      T_CAP:   top_o = cap_i;
      default: top_o = '1;
    endcase
  end
endmodule

// File: rtl/wavegen_counter.sv
module wavegen_counter
  import wavegen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  kind_e            kind_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             ev_top_o,
  output logic             ev_bot_o,
  output logic             ev_max_o
);
  localparam logic [CNT_W-1:0] MAX_V = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (en_i) begin
      unique case (kind_i)
        K_DUAL: begin
          if (up_q) begin
            if (cnt_q == top_i) begin
              if (top_i != '0) begin
                up_q  <= 1'b0;
                cnt_q <= cnt_q - 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else if (cnt_q == '0) begin
            up_q  <= 1'b1;
            cnt_q <= (top_i == '0) ? '0 : CNT_W'(1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        K_CTC, K_FAST: begin
          up_q  <= 1'b1;
          cnt_q <= (cnt_q == top_i) ? '0 : cnt_q + 1'b1;
        end
        default: begin
          up_q  <= 1'b1;
          cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  // events mark the count being left on this edge
  assign ev_top_o = en_i && (cnt_q == top_i);
  assign ev_bot_o = en_i && (cnt_q == '0) && !up_q;
  assign ev_max_o = en_i && (cnt_q == MAX_V);
  assign cnt_o    = cnt_q;
  assign up_o     = up_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));
  p_dual_turn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_DUAL && en_i && up_q && cnt_q == top_i && top_i != '0)
      |=> (!up_o && cnt_o == $past(cnt_q) - 1'b1));
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kind_i == K_CTC || kind_i == K_FAST) && en_i && cnt_q == top_i) |=> cnt_o == '0);
endmodule

// File: rtl/wavegen_cmp_chan.sv
module wavegen_cmp_chan
  import wavegen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             imm_i,
  input  logic             load_i,
  input  logic             en_i,
  input  kind_e            kind_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] act_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] buf_q, act_q;
  logic             pwm_q;
  logic             match;

  assign match = en_i && (cnt_i == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i) buf_q <= wdata_i;
      if (imm_i && we_i) act_q <= wdata_i;
      else if (load_i)   act_q <= buf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
    end else begin
      unique case (kind_i)
        K_FAST: begin
          if (wrap_i)     pwm_q <= 1'b1;  // wrap wins over match
          else if (match) pwm_q <= 1'b0;
        end
        K_DUAL: if (match) pwm_q <= !up_i;
        default: pwm_q <= 1'b0;
      endcase
    end
  end

  assign act_o = act_q;
  assign pwm_o = pwm_q;

  p_act_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(imm_i && we_i) && !load_i) |=> $stable(act_o));
  p_pwm_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_NORM || kind_i == K_CTC) |=> !pwm_o);
endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
  import wavegen_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cnt_en_i,
  input  logic [3:0]  mode_i,
  input  logic        ocra_we_i,
  input  logic        ocrb_we_i,
  input  logic        cap_we_i,
  input  logic [15:0] wdata_i,
  input  logic        ovf_clr_i,
  output logic [15:0] cnt_o,
  output logic        ovf_flag_o,
  output logic        pwm_a_o,
  output logic        pwm_b_o
);
  localparam int CNT_W = 16;
  localparam int N_CH  = 2;

  mode_cfg_t        cfg;
  logic [CNT_W-1:0] top_v, cnt, cap_q;
  logic [CNT_W-1:0] act [N_CH];
  logic [N_CH-1:0]  we_v, pwm_v;
  logic             up, ev_top, ev_bot, ev_max;
  logic             load, set_ev, ovf_q;

  assign we_v = {ocrb_we_i, ocra_we_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_q <= '0;
    else if (cap_we_i) cap_q <= wdata_i;
  end

  wavegen_mode_dec #(.CNT_W(CNT_W)) u_dec (
    .mode_i     (mode_i),
    .cmpa_act_i (act[0]),
    .cap_i      (cap_q),
    .cfg_o      (cfg),
    .top_o      (top_v)
  );

  wavegen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .kind_i   (cfg.kind),
    .top_i    (top_v),
    .cnt_o    (cnt),
    .up_o     (up),
    .ev_top_o (ev_top),
    .ev_bot_o (ev_bot),
    .ev_max_o (ev_max)
  );

  always_comb begin
    unique case (cfg.upd)
      U_TOP:   load = ev_top;
      U_BOT:   load = ev_bot;
      default: load = 1'b0;
    endcase
    unique case (cfg.flg)
      F_TOP:   set_ev = ev_top;
      F_BOT:   set_ev = ev_bot;
      default: set_ev = ev_max;
    endcase
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    wavegen_cmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_v[g]),
      .wdata_i (wdata_i),
      .imm_i   (cfg.upd == U_IMM),
      .load_i  (load),
      .en_i    (cnt_en_i),
      .kind_i  (cfg.kind),
      .cnt_i   (cnt),
      .up_i    (up),
      .wrap_i  (ev_top),
      .act_o   (act[g]),
      .pwm_o   (pwm_v[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (set_ev)    ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o      = cnt;
  assign ovf_flag_o = ovf_q;
  assign pwm_a_o    = pwm_v[0];
  assign pwm_b_o    = pwm_v[1];

  p_ovf_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> ovf_flag_o);
  p_ovf_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !set_ev) |=> !ovf_flag_o);
  p_ovf_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_clr_i && !set_ev) |=> $stable(ovf_flag_o));
endmodule

// File: tb/wavegen_timer_tb_top.sv
module wavegen_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        wa = 1'b0, wb = 1'b0, wc = 1'b0, clr = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] cnt;
  logic        ovf, pa, pb;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  wavegen_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .mode_i(mode),
    .ocra_we_i(wa), .ocrb_we_i(wb), .cap_we_i(wc), .wdata_i(wd),
    .ovf_clr_i(clr), .cnt_o(cnt), .ovf_flag_o(ovf), .pwm_a_o(pa), .pwm_b_o(pb)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; en = 1'b0; clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      en = 1'b1;
      @(negedge clk);
    end
    en = 1'b0;
  endtask

  // 0 = A, 1 = B, 2 = capture
  task automatic wr(input int which, input logic [15:0] d);
    wd = d;
    wa = (which == 0); wb = (which == 1); wc = (which == 2);
    @(negedge clk);
    wa = 1'b0; wb = 1'b0; wc = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(4'd5);
    chk("R1", "cnt", cnt, 0);
    chk("R1", "ovf", ovf, 0);
    chk("R1", "pwm_a", pa, 0);
    chk("R1", "pwm_b", pb, 0);
  endtask

  task automatic t_normal;
    do_reset(4'd0);
    step(3);
    chk("R2", "cnt after 3 ticks", cnt, 3);
    repeat (5) @(negedge clk);
    chk("R2", "cnt held with enable low", cnt, 3);
    step(65532);
    chk("R3", "cnt at max", cnt, 16'hFFFF);
    chk("R3", "ovf before wrap", ovf, 0);
    step(1);
    chk("R3", "cnt wrap", cnt, 0);
    chk("R3", "ovf after wrap", ovf, 1);
    chk("R10", "pwm_a low in normal", pa, 0);
  endtask

  task automatic t_reserved;
    do_reset(4'd13);
    wr(2, 16'd2);
    step(5);
    chk("R3", "reserved mode counts past capture", cnt, 5);
    chk("R10", "pwm_b low in reserved", pb, 0);
  endtask

  task automatic t_ctc;
    do_reset(4'd4);
    wr(0, 16'd5);
    step(5);
    chk("R4", "cnt at TOP", cnt, 5);
    step(1);
    chk("R4", "cnt cleared after TOP", cnt, 0);
    chk("R4", "ovf not set at TOP", ovf, 0);
    wr(0, 16'd2);
    step(2);
    chk("R7", "immediate compare gives TOP 2", cnt, 2);
    step(1);
    chk("R7", "cleared after new TOP", cnt, 0);
    chk("R10", "pwm_a low in CTC", pa, 0);
  endtask

  task automatic t_fast8;
    do_reset(4'd5);
    wr(0, 16'h0080);
    wr(1, 16'h00FF);
    step(255);
    chk("R5", "cnt at 0xFF", cnt, 16'h00FF);
    chk("R5", "ovf before TOP left", ovf, 0);
    step(1);
    chk("R5", "wrap to 0", cnt, 0);
    chk("R5", "ovf at TOP", ovf, 1);
    chk("R8", "pwm_a set at wrap", pa, 1);
    step(16);
    wr(0, 16'h0040);
    step(64);
    chk("R7", "old compare still active at 0x50", pa, 1);
    step(49);
    chk("R8", "pwm_a cleared after 0x80", pa, 0);
    step(127);
    chk("R8", "pwm_b held when compare equals TOP", pb, 1);
    step(64);
    chk("R7", "new compare active at 0x40", pa, 1);
    step(1);
    chk("R7", "pwm_a cleared after 0x40", pa, 0);
  endtask

  task automatic t_fast9;
    do_reset(4'd6);
    step(511);
    chk("R5", "9-bit TOP reached", cnt, 16'h01FF);
    step(1);
    chk("R5", "9-bit wrap", cnt, 0);
  endtask

  task automatic t_dual8;
    do_reset(4'd1);
    wr(0, 16'h0040);
    step(255);
    chk("R6", "up to TOP", cnt, 16'h00FF);
    chk("R6", "no ovf at TOP", ovf, 0);
    step(1);
    chk("R6", "down after TOP", cnt, 16'h00FE);
    step(189);
    chk("R9", "pwm_a low above compare going down", pa, 0);
    step(2);
    chk("R9", "pwm_a set after down match", pa, 1);
    step(63);
    chk("R6", "bottom", cnt, 0);
    chk("R6", "ovf before bottom left", ovf, 0);
    step(1);
    chk("R6", "up after bottom", cnt, 1);
    chk("R6", "ovf at bottom", ovf, 1);
    step(63);
    chk("R9", "pwm_a high at compare going up", pa, 1);
    step(1);
    chk("R9", "pwm_a cleared after up match", pa, 0);
  endtask

  task automatic t_dual10;
    do_reset(4'd3);
    step(1024);
    chk("R6", "10-bit turn", cnt, 16'h03FE);
  endtask

  task automatic t_pfc;
    do_reset(4'd8);
    wr(2, 16'h0010);
    wr(1, 16'h0008);
    step(25);
    chk("R7", "compare B not loaded at TOP", pb, 0);
    step(7);
    chk("R6", "capture TOP bottom", cnt, 0);
    chk("R6", "ovf before bottom left", ovf, 0);
    step(1);
    chk("R6", "ovf at bottom", ovf, 1);
    chk("R9", "pwm_b set at bottom match", pb, 1);
    step(7);
    chk("R7", "pwm_b high at loaded compare", pb, 1);
    step(1);
    chk("R7", "pwm_b cleared after loaded compare", pb, 0);
    step(15);
    chk("R9", "pwm_b low at compare going down", pb, 0);
    step(1);
    chk("R9", "pwm_b set below compare going down", pb, 1);
  endtask

  task automatic t_flag;
    do_reset(4'd14);
    wr(2, 16'd3);
    step(3);
    chk("R5", "capture TOP", cnt, 3);
    chk("R5", "ovf before TOP left", ovf, 0);
    step(1);
    chk("R5", "ovf at capture TOP", ovf, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R11", "flag cleared", ovf, 0);
    repeat (3) @(negedge clk);
    chk("R11", "flag stays clear", ovf, 0);
    step(3);
    en = 1'b1; clr = 1'b1;
    @(negedge clk);
    en = 1'b0; clr = 1'b0;
    chk("R11", "set wins over clear", ovf, 1);
    chk("R5", "wrap with clear", cnt, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_reserved();
    t_ctc();
    t_fast8();
    t_fast9();
    t_dual8();
    t_dual10();
    t_pfc();
    t_flag();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule